// File: doc/BRIEF.md
# Serial Channel Interrupt and DMA Request Controller

This block sits next to one serial channel. It keeps four status flags: receive data waiting, transmit register empty, receive overrun, and transmit underrun. It turns those flags into interrupt requests. For the two data flags it also drives a DMA request handshake. The shift logic reports its events as one-cycle strobes. A small register bus lets software enable the two data interrupts, read the flags and clear the error flags. The DMA engine acknowledges each data-register access with a one-cycle strobe.

The two error requests have no enable and never start a DMA transfer. The two data flags clear on their own when the matching data register is accessed, either by the DMA engine or by the CPU. A fixed-priority encoder reduces the pending, enabled requests to one valid bit and a 2-bit source code for the system interrupt controller.

DMA handshake rule: each DMA request acts as a valid signal. It stays high until the matching acknowledge strobe (the ready side) clears the flag. A request is never withdrawn while its enable and flag are both set. A new event in the same cycle as an acknowledge keeps the request high for the next item.

Top module: `sio_irq_ctrl`

## Requirements
- R1: After reset the status reads 0x08 (only transmit-empty set), the control register reads 0, and all interrupt and DMA request outputs are low.
- R2: A receive-full event sets status bit 2. `irq_req[2]` equals that flag ANDed with control bit 0 (receive interrupt enable).
- R3: A transmit-empty event sets status bit 3. `irq_req[3]` equals that flag ANDed with control bit 1 (transmit interrupt enable).
- R4: The receive DMA request equals the receive-full flag ANDed with control bit 0. The transmit DMA request equals the transmit-empty flag ANDed with control bit 1. Both are low while their enable is 0.
- R5: A DMA receive acknowledge clears the receive-full flag, and a DMA transmit acknowledge clears the transmit-empty flag, in the next cycle. A set event in the same cycle wins over the clear.
- R6: A CPU read of address 2 (receive data) clears the receive-full flag. A CPU write to address 3 (transmit data) clears the transmit-empty flag. Both reads return 0.
- R7: A receive-full event while the receive-full flag is 1 and not being cleared in that cycle sets the overrun flag (status bit 0). `irq_req[0]` follows this flag whatever the enables hold.
- R8: A transmit-underrun event sets status bit 1. `irq_req[1]` follows that flag with no enable. Neither error flag affects a DMA request.
- R9: An error flag clears only on a status write with a 0 in its bit, and only when the most recent status read returned 1 for that bit. Any status write disarms both bits.
- R10: A new error event in the same cycle as a clearing write leaves that flag set.
- R11: `irq_valid` is high when any `irq_req` bit is high. `irq_code` is the lowest set index: 0 overrun, 1 underrun, 2 receive full, 3 transmit empty.
- R12: Address 0 is control (bit 0 receive enable, bit 1 transmit enable, other bits read 0). Address 1 is status. Status writes never change bits 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_rx_full | input | 1 | Shift logic loaded a received character |
| ev_tx_empty | input | 1 | Shift logic took the transmit character |
| ev_tx_underrun | input | 1 | Transmitter ran dry |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| dma_rx_req | output | 1 | Receive DMA request (valid) |
| dma_rx_ack | input | 1 | DMA read the receive data register |
| dma_tx_req | output | 1 | Transmit DMA request (valid) |
| dma_tx_ack | input | 1 | DMA wrote the transmit data register |
| irq_req | output | 4 | Per-source masked requests, indexed by source code |
| irq_valid | output | 1 | Any request pending |
| irq_code | output | 2 | Highest-priority pending source |

## Verification
Every flag changes at the clock edge that samples its event, acknowledge or bus strobe. The requests, the priority code and the status readback follow the flags with no further register, so all results are due one edge after the stimulus. The bus read data is due in the same cycle as the address. The bench drives on the falling edge. It samples read data one time unit after driving it, and it samples the request outputs at the next falling edge, one full rising edge later. Same-cycle collisions are checked with both strobes driven in that single cycle.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
  localparam int NSRC = 4;
  localparam int CW   = $clog2(NSRC);

  typedef enum logic [1:0] {
    SRC_OVR = 2'd0,
    SRC_UDR = 2'd1,
    SRC_RXF = 2'd2,
    SRC_TXE = 2'd3
  } src_e;

  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_STAT = 2'd1;
  localparam logic [1:0] ADR_RXD  = 2'd2;
  localparam logic [1:0] ADR_TXD  = 2'd3;

  localparam logic [NSRC-1:0] FLAG_RST = 4'b1000;
endpackage

// File: rtl/sio_irq_regif.sv
module sio_irq_regif
  import sio_irq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_we,
  input  logic [1:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] flags,
  output logic            rx_ie,
  output logic            tx_ie,
  output logic            stat_rd,
  output logic            stat_wr,
  output logic            rxd_rd,
  output logic            txd_wr
);
  logic ctrl_wr;

  assign ctrl_wr = bus_sel &  bus_we & (bus_addr == ADR_CTRL);
  assign stat_wr = bus_sel &  bus_we & (bus_addr == ADR_STAT);
  assign stat_rd = bus_sel & ~bus_we & (bus_addr == ADR_STAT);
  assign rxd_rd  = bus_sel & ~bus_we & (bus_addr == ADR_RXD);
  assign txd_wr  = bus_sel &  bus_we & (bus_addr == ADR_TXD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ie <= 1'b0;
      tx_ie <= 1'b0;
    end else if (ctrl_wr) begin
      rx_ie <= bus_wdata[0];
      tx_ie <= bus_wdata[1];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      unique case (bus_addr)
        ADR_CTRL: bus_rdata = DW'({tx_ie, rx_ie});
        ADR_STAT: bus_rdata = DW'(flags);
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/sio_irq_flags.sv
module sio_irq_flags
  import sio_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_rx,
  input  logic            ev_tx,
  input  logic            ev_udr,
  input  logic            clr_rx,
  input  logic            clr_tx,
  input  logic            stat_rd,
  input  logic            stat_wr,
  input  logic [1:0]      wr_err,
  output logic [NSRC-1:0] flags
);
  logic [1:0] err_q, err_set, err_clr, err_d, arm_q;
  logic       rxf_q, txe_q, rxf_d, txe_d;

  assign err_set[0] = ev_rx & rxf_q & ~clr_rx;
  assign err_set[1] = ev_udr;

  assign rxf_d = ev_rx | (rxf_q & ~clr_rx);
  assign txe_d = ev_tx | (txe_q & ~clr_tx);

  for (genvar g = 0; g < 2; g++) begin : g_err
    assign err_clr[g] = stat_wr & ~wr_err[g] & arm_q[g];
    assign err_d[g]   = err_set[g] | (err_q[g] & ~err_clr[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= FLAG_RST[1:0];
      rxf_q <= FLAG_RST[SRC_RXF];
      txe_q <= FLAG_RST[SRC_TXE];
      arm_q <= 2'b00;
    end else begin
      err_q <= err_d;
      rxf_q <= rxf_d;
      txe_q <= txe_d;
      if (stat_rd)      arm_q <= err_q;
      else if (stat_wr) arm_q <= 2'b00;
    end
  end

  assign flags = {txe_q, rxf_q, err_q};
endmodule

// File: rtl/sio_irq_prio.sv
module sio_irq_prio #(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  output logic         valid,
  output logic [W-1:0] code
);
  always_comb begin
    code  = '0;
    valid = |req;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) code = W'(i);
    end
  end
endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl
  import sio_irq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_rx_full,
  input  logic            ev_tx_empty,
  input  logic            ev_tx_underrun,
  input  logic            bus_sel,
  input  logic            bus_we,
  input  logic [1:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            dma_rx_req,
  input  logic            dma_rx_ack,
  output logic            dma_tx_req,
  input  logic            dma_tx_ack,
  output logic [NSRC-1:0] irq_req,
  output logic            irq_valid,
  output logic [CW-1:0]   irq_code
);
  logic [NSRC-1:0] flags, en_mask;
  logic rx_ie, tx_ie, stat_rd, stat_wr, rxd_rd, txd_wr, clr_rx, clr_tx;

  sio_irq_regif #(.DW(DW)) u_regif (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .flags(flags), .rx_ie(rx_ie), .tx_ie(tx_ie),
    .stat_rd(stat_rd), .stat_wr(stat_wr), .rxd_rd(rxd_rd), .txd_wr(txd_wr)
  );

  assign clr_rx = dma_rx_ack | rxd_rd;
  assign clr_tx = dma_tx_ack | txd_wr;

  sio_irq_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .ev_rx(ev_rx_full), .ev_tx(ev_tx_empty), .ev_udr(ev_tx_underrun),
    .clr_rx(clr_rx), .clr_tx(clr_tx),
    .stat_rd(stat_rd), .stat_wr(stat_wr), .wr_err(bus_wdata[1:0]),
    .flags(flags)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_mask
    if (s == int'(SRC_RXF))      begin : g_rx  assign en_mask[s] = rx_ie; end
    else if (s == int'(SRC_TXE)) begin : g_tx  assign en_mask[s] = tx_ie; end
    else                         begin : g_err assign en_mask[s] = 1'b1;  end
  end

  assign irq_req    = flags & en_mask;
  assign dma_rx_req = irq_req[SRC_RXF];
  assign dma_tx_req = irq_req[SRC_TXE];

  sio_irq_prio #(.N(NSRC)) u_prio (
    .req(irq_req), .valid(irq_valid), .code(irq_code)
  );
endmodule

// File: rtl/sio_irq_ctrl_chk.sv
module sio_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_rx_full,
  input logic       ev_tx_underrun,
  input logic       dma_rx_ack,
  input logic       dma_rx_req,
  input logic       rx_ie,
  input logic       clr_rx,
  input logic       stat_wr,
  input logic [3:0] flags,
  input logic [3:0] irq_req,
  input logic       irq_valid,
  input logic [1:0] irq_code
);
  // R8
  udr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_underrun |=> irq_req[1]);
  // R7
  ovr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_full && flags[2] && !clr_rx |=> irq_req[0]);
  // R4
  dma_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ie |-> !dma_rx_req);
  // R5
  rx_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rx_ack && !ev_rx_full |=> !flags[2]);
  // R11
  prio_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req[0] |-> irq_valid && irq_code == 2'd0);
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags[0] && !stat_wr |=> flags[0]);
endmodule

bind sio_irq_ctrl sio_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_rx_full(ev_rx_full),
  .ev_tx_underrun(ev_tx_underrun), .dma_rx_ack(dma_rx_ack),
  .dma_rx_req(dma_rx_req), .rx_ie(rx_ie), .clr_rx(clr_rx),
  .stat_wr(stat_wr), .flags(flags), .irq_req(irq_req),
  .irq_valid(irq_valid), .irq_code(irq_code)
);

// File: tb/sio_irq_ctrl_test.sv
module sio_irq_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_rx_full = 0, ev_tx_empty = 0, ev_tx_underrun = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic dma_rx_req, dma_rx_ack = 0, dma_tx_req, dma_tx_ack = 0;
  logic [3:0] irq_req;
  logic irq_valid;
  logic [1:0] irq_code;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  sio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ev_rx_full(ev_rx_full), .ev_tx_empty(ev_tx_empty),
    .ev_tx_underrun(ev_tx_underrun), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dma_rx_req(dma_rx_req), .dma_rx_ack(dma_rx_ack), .dma_tx_req(dma_tx_req),
    .dma_tx_ack(dma_tx_ack), .irq_req(irq_req), .irq_valid(irq_valid), .irq_code(irq_code)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ev_rx_full = 0; ev_tx_empty = 0; ev_tx_underrun = 0;
    dma_rx_ack = 0; dma_tx_ack = 0; bus_sel = 0; bus_we = 0;
  endtask

  task automatic pulse(input logic rx, input logic tx, input logic udr,
                       input logic rack, input logic tack);
    ev_rx_full = rx; ev_tx_empty = tx; ev_tx_underrun = udr;
    dma_rx_ack = rack; dma_tx_ack = tack;
    @(negedge clk); idle();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); idle();
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); idle();
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq_req", irq_req, 0);
    chk("R1 valid", irq_valid, 0);
    chk("R1 dma", {dma_rx_req, dma_tx_req}, 0);
    rd(2'd1, d); chk("R1 status", d, 8'h08);
    rd(2'd0, d); chk("R1 ctrl", d, 8'h00);
  endtask

  task automatic t_rx_path();
    logic [7:0] d;
    pulse(1, 0, 0, 0, 0);
    chk("R4 rx req masked", dma_rx_req, 0);
    chk("R2 irq masked", irq_req, 0);
    rd(2'd1, d); chk("R2 status", d, 8'h0C);
    wr(2'd0, 8'h01);
    chk("R2 irq", irq_req, 4'b0100);
    chk("R4 rx req", dma_rx_req, 1);
    chk("R11 code rx", {irq_valid, irq_code}, 3'b110);
    pulse(0, 0, 0, 1, 0);
    chk("R5 rx ack", dma_rx_req, 0);
  endtask

  task automatic t_tx_path();
    wr(2'd0, 8'h03);
    chk("R3 irq", irq_req, 4'b1000);
    chk("R4 tx req", dma_tx_req, 1);
    chk("R11 code tx", {irq_valid, irq_code}, 3'b111);
    pulse(0, 0, 0, 0, 1); chk("R5 tx ack", dma_tx_req, 0);
    pulse(0, 1, 0, 0, 0); chk("R3 tx event", dma_tx_req, 1);
    pulse(0, 1, 0, 0, 1); chk("R5 event wins", dma_tx_req, 1);
    wr(2'd3, 8'h55);      chk("R6 cpu tx write", dma_tx_req, 0);
    pulse(0, 1, 0, 0, 0);
  endtask

  task automatic t_cpu_rx();
    logic [7:0] d;
    pulse(1, 0, 0, 0, 0); chk("R4 rx req set", dma_rx_req, 1);
    rd(2'd2, d); chk("R6 rxd reads 0", d, 0);
    chk("R6 cpu rx read", dma_rx_req, 0);
    rd(2'd1, d); chk("R7 no overrun", d, 8'h08);
  endtask

  task automatic t_overrun();
    pulse(1, 0, 0, 0, 0);
    pulse(1, 0, 0, 1, 0);
    chk("R7 ack same cycle", irq_req[0], 0);
    chk("R5 rx event wins", dma_rx_req, 1);
    pulse(1, 0, 0, 0, 0);
    chk("R7 overrun", irq_req[0], 1);
    chk("R11 code ovr", {irq_valid, irq_code}, 3'b100);
    wr(2'd0, 8'h00);
    chk("R7 unmasked", irq_req, 4'b0001);
    pulse(0, 0, 0, 1, 0);
    chk("R7 sticky after ack", irq_req, 4'b0001);
  endtask

  task automatic t_underrun();
    pulse(0, 0, 1, 0, 0);
    chk("R8 underrun", irq_req, 4'b0011);
    chk("R8 no dma", {dma_rx_req, dma_tx_req}, 0);
    chk("R11 code", {irq_valid, irq_code}, 3'b100);
  endtask

  task automatic t_sticky();
    logic [7:0] d;
    wr(2'd1, 8'h00);
    rd(2'd1, d); chk("R9 no arm", d, 8'h0B);
    wr(2'd1, 8'h03);
    rd(2'd1, d); chk("R9 write one", d, 8'h0B);
    bus_sel = 1; bus_we = 1; bus_addr = 2'd1; bus_wdata = 8'h00; ev_tx_underrun = 1;
    @(negedge clk); idle();
    rd(2'd1, d); chk("R10 event wins", d, 8'h0A);
    wr(2'd1, 8'h00);
    rd(2'd1, d); chk("R9 cleared", d, 8'h08);
    chk("R12 data bits kept", d[3], 1);
  endtask

  task automatic t_regmap();
    logic [7:0] d;
    wr(2'd0, 8'hFF);
    rd(2'd0, d); chk("R12 ctrl", d, 8'h03);
    rd(2'd3, d); chk("R12 txd reads 0", d, 8'h00);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_rx_path();
    t_tx_path();
    t_cpu_rx();
    t_overrun();
    t_underrun();
    t_sticky();
    t_regmap();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule